// File: doc/BRIEF.md
# Early Compare-and-Branch Resolver

This unit settles change-of-flow instructions while they are still in the decode stage of a five-stage pipeline. It does not wait for the general execute unit. It receives the decoded branch kind, a 3-bit condition code, the branch PC, a word offset and up to two register operands. A small dedicated comparator decides taken or not-taken in the same cycle the branch is presented. One register stage later, the unit drives the fetch stage with a single-cycle redirect strobe and the target address.

The architecture defines two delay slots after every change of flow, and both always execute. The redirect is registered so that it is visible while fetch brings in the second delay-slot instruction. Fetch therefore loads the target on the following cycle. A not-taken branch produces no redirect, and fetch simply continues sequentially. A subroutine call also reports a link address, which is the return point after both delay slots. Any change-of-flow instruction presented in one of the two delay slots of an accepted one is ignored.

Top module: `bru_branch_unit`

## Requirements
- R1: While rst_ni is low, and after reset until a branch is accepted, redirect_o, link_we_o, target_o and link_addr_o are all 0.
- R2: For a conditional branch (kind 2'b00), condition 3'b000 is taken when opa_i equals opb_i, and condition 3'b001 is taken when they differ.
- R3: For a conditional branch, the sign and zero tests are applied to a test value. The test value is opa_i when diff_sel_i is 0, and the wrapped difference opa_i minus opb_i when diff_sel_i is 1. The codes are:
  - 3'b010: taken when the MSB is 1.
  - 3'b011: taken when the MSB is 0 and the value is nonzero.
  - 3'b100: taken when the MSB is 1 or the value is zero.
  - 3'b101: taken when the MSB is 0.
  - 3'b110: taken when the value is zero.
- R4: A conditional branch with condition 3'b111 is always taken.
- R5: A taken branch accepted at a clock edge raises redirect_o for exactly the next cycle. For kinds 00, 01 and 10, target_o in that cycle is pc_i + 4 + (sign-extended offset_i shifted left by 2).
- R6: A not-taken branch produces no redirect. target_o reads 0 in every cycle where redirect_o is low.
- R7: Jump (kind 2'b01) and call (kind 2'b10) are taken whatever the condition and operands are. A call also raises link_we_o in the redirect cycle, with link_addr_o = pc_i + 12. link_addr_o is 0 whenever link_we_o is low.
- R8: Return (kind 2'b11) is always taken, with target_o equal to opa_i with its two low bits cleared. It does not raise link_we_o.
- R9: A branch is accepted only when br_valid_i is high and neither of the two preceding cycles accepted a branch. A branch presented in either delay slot of an accepted branch, taken or not, produces no redirect and no link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| br_valid_i | input | 1 | Decode holds a change-of-flow instruction |
| br_kind_i | input | 2 | 00 conditional, 01 jump, 10 call, 11 return |
| br_cond_i | input | 3 | Condition code (see R2 to R4) |
| diff_sel_i | input | 1 | Test opa_i minus opb_i instead of opa_i |
| pc_i | input | 32 | Address of the branch instruction |
| offset_i | input | 16 | Signed word offset |
| opa_i | input | 32 | First register operand, or return address |
| opb_i | input | 32 | Second register operand |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| target_o | output | 32 | Redirect address, 0 when idle |
| link_we_o | output | 1 | Call link write strobe |
| link_addr_o | output | 32 | Return address after both delay slots |

## Verification
The assertions assume that decode never keeps one branch on br_valid_i across several cycles expecting it to be taken again. They also assume that nothing other than a new instruction reaches the unit in the two cycles after a branch. The bench follows this by driving every accepted branch for a single cycle. In the two delay-slot cycles it drives random instructions, often with valid set, so that the ignore rule is exercised. Operands are biased toward zero and toward equal pairs so that the boundaries of every test are reached. PCs are word aligned, as fetch would supply them.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic [1:0] {
    KIND_BRANCH = 2'b00,
    KIND_JUMP   = 2'b01,
    KIND_CALL   = 2'b10,
    KIND_RETURN = 2'b11
  } br_kind_e;

  typedef enum logic [2:0] {
    COND_EQ     = 3'b000,
    COND_NE     = 3'b001,
    COND_LTZ    = 3'b010,
    COND_GTZ    = 3'b011,
    COND_LEZ    = 3'b100,
    COND_GEZ    = 3'b101,
    COND_EQZ    = 3'b110,
    COND_ALWAYS = 3'b111
  } br_cond_e;

  localparam int unsigned INSTR_BYTES = 4;
endpackage

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
  import bru_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [2:0]      cond_i,
  input  logic            diff_sel_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic            hit_o
);
  logic [XLEN-1:0] diff;
  logic [XLEN-1:0] test_val;
  logic            neg;
  logic            zero;
  logic            same;
  br_cond_e        cond;

  assign diff     = opa_i - opb_i;
  assign test_val = diff_sel_i ? diff : opa_i;
  assign neg      = test_val[XLEN-1];
  assign zero     = ~|test_val;
  assign same     = (opa_i == opb_i);
  assign cond     = br_cond_e'(cond_i);

  always_comb begin
    unique case (cond)
      COND_EQ:     hit_o = same;
      COND_NE:     hit_o = ~same;
      COND_LTZ:    hit_o = neg;
      COND_GTZ:    hit_o = ~neg & ~zero;
      COND_LEZ:    hit_o = neg | zero;
      COND_GEZ:    hit_o = ~neg;
      COND_EQZ:    hit_o = zero;
      COND_ALWAYS: hit_o = 1'b1;
      default:     hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bru_target_gen.sv
module bru_target_gen
  import bru_pkg::*;
#(
  parameter int unsigned XLEN            = 32,
  parameter int unsigned OFF_W           = 16,
  parameter int unsigned NUM_DELAY_SLOTS = 2
) (
  input  logic [1:0]       kind_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [XLEN-1:0]  opa_i,
  output logic [XLEN-1:0]  target_o,
  output logic [XLEN-1:0]  link_addr_o
);
  localparam int unsigned EXT_W     = XLEN - OFF_W - 2;
  localparam int unsigned LINK_STEP = INSTR_BYTES * (NUM_DELAY_SLOTS + 1);

  logic [XLEN-1:0] rel_disp;
  logic [XLEN-1:0] rel_target;
  br_kind_e        kind;

  assign kind        = br_kind_e'(kind_i);
  assign rel_disp    = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, 2'b00};
  assign rel_target  = pc_i + XLEN'(INSTR_BYTES) + rel_disp;
  assign link_addr_o = pc_i + XLEN'(LINK_STEP);

  always_comb begin
    if (kind == KIND_RETURN) target_o = {opa_i[XLEN-1:2], 2'b00};
    else                     target_o = rel_target;
  end
endmodule

// File: rtl/bru_slot_tracker.sv
module bru_slot_tracker #(
  parameter int unsigned NUM_DELAY_SLOTS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic accept_o
);
  localparam int unsigned CNT_W = $clog2(NUM_DELAY_SLOTS + 1);

  logic [CNT_W-1:0] slots_left_q;

  assign accept_o = valid_i && (slots_left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 slots_left_q <= '0;
    else if (accept_o)           slots_left_q <= CNT_W'(NUM_DELAY_SLOTS);
    else if (slots_left_q != '0) slots_left_q <= slots_left_q - 1'b1;
  end
endmodule

// File: rtl/bru_branch_unit.sv
module bru_branch_unit
  import bru_pkg::*;
#(
  parameter int unsigned XLEN            = 32,
  parameter int unsigned OFF_W           = 16,
  parameter int unsigned NUM_DELAY_SLOTS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             br_valid_i,
  input  logic [1:0]       br_kind_i,
  input  logic [2:0]       br_cond_i,
  input  logic             diff_sel_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [XLEN-1:0]  opa_i,
  input  logic [XLEN-1:0]  opb_i,
  output logic             redirect_o,
  output logic [XLEN-1:0]  target_o,
  output logic             link_we_o,
  output logic [XLEN-1:0]  link_addr_o
);
  logic            cond_hit;
  logic            accept;
  logic            taken;
  logic            is_call;
  logic [XLEN-1:0] target_d;
  logic [XLEN-1:0] link_d;
  br_kind_e        kind;

  assign kind = br_kind_e'(br_kind_i);

  bru_cond_eval #(.XLEN(XLEN)) u_cond (
    .cond_i     (br_cond_i),
    .diff_sel_i (diff_sel_i),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .hit_o      (cond_hit)
  );

  bru_target_gen #(
    .XLEN            (XLEN),
    .OFF_W           (OFF_W),
    .NUM_DELAY_SLOTS (NUM_DELAY_SLOTS)
  ) u_tgt (
    .kind_i      (br_kind_i),
    .pc_i        (pc_i),
    .offset_i    (offset_i),
    .opa_i       (opa_i),
    .target_o    (target_d),
    .link_addr_o (link_d)
  );

  bru_slot_tracker #(.NUM_DELAY_SLOTS(NUM_DELAY_SLOTS)) u_slots (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (br_valid_i),
    .accept_o (accept)
  );

  // only conditional branches consult the comparator
  assign taken   = accept && ((kind != KIND_BRANCH) || cond_hit);
  assign is_call = accept && (kind == KIND_CALL);

  // registered so the strobe lines up with fetch of the last delay slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o  <= 1'b0;
      target_o    <= '0;
      link_we_o   <= 1'b0;
      link_addr_o <= '0;
    end else begin
      redirect_o  <= taken;
      target_o    <= taken ? target_d : '0;
      link_we_o   <= is_call;
      link_addr_o <= is_call ? link_d : '0;
    end
  end
endmodule

// File: rtl/bru_checker.sv
module bru_checker #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            br_valid_i,
  input logic [1:0]      br_kind_i,
  input logic            redirect_o,
  input logic [XLEN-1:0] target_o,
  input logic            link_we_o,
  input logic [XLEN-1:0] link_addr_o
);
  assert_rst_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (!redirect_o && !link_we_o) || rst_ni);

  assert_redirect_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> $past(br_valid_i));

  assert_idle_target_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redirect_o |-> (target_o == '0));

  assert_link_with_redirect_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> redirect_o && (link_addr_o != '0 || target_o != '0 || 1'b1) && $past(br_kind_i) == 2'b10);

  assert_link_idle_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_we_o |-> (link_addr_o == '0));

  assert_return_aligned_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && $past(br_kind_i) == 2'b11) |-> (target_o[1:0] == 2'b00) && !link_we_o);

  assert_slot_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !redirect_o ##1 !redirect_o);
endmodule

bind bru_branch_unit bru_checker #(.XLEN(XLEN)) u_bru_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .br_valid_i  (br_valid_i),
  .br_kind_i   (br_kind_i),
  .redirect_o  (redirect_o),
  .target_o    (target_o),
  .link_we_o   (link_we_o),
  .link_addr_o (link_addr_o)
);

// File: tb/bru_branch_unit_bench.sv
module bru_branch_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        br_valid_i = 1'b0;
  logic [1:0]  br_kind_i = '0;
  logic [2:0]  br_cond_i = '0;
  logic        diff_sel_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic [15:0] offset_i = '0;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic        redirect_o;
  logic [31:0] target_o;
  logic        link_we_o;
  logic [31:0] link_addr_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  bru_branch_unit u_bru_branch_unit (.*);

  function automatic logic ref_taken(logic [1:0] k, logic [2:0] c, logic ds,
                                     logic [31:0] a, logic [31:0] b);
    logic [31:0] v;
    logic n, z;
    if (k != 2'b00) return 1'b1;
    v = ds ? (a - b) : a;
    n = v[31];
    z = (v == 32'd0);
    case (c)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd2: return n;
      3'd3: return !n && !z;
      3'd4: return n || z;
      3'd5: return !n;
      3'd6: return z;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] ref_target(logic [1:0] k, logic [31:0] pc,
                                             logic [15:0] off, logic [31:0] a);
    int signed soff;
    if (k == 2'b11) return a & 32'hFFFF_FFFC;
    soff = int'($signed(off));
    return pc + 32'd4 + 32'(soff * 4);
  endfunction

  function automatic string tag_for(logic [1:0] k, logic [2:0] c);
    if (k == 2'b11) return "R8";
    if (k != 2'b00) return "R7";
    if (c <= 3'd1)  return "R2";
    if (c == 3'd7)  return "R4";
    return "R3";
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [1:0] k, logic [2:0] c, logic ds,
                       logic [31:0] pc, logic [15:0] off, logic [31:0] a, logic [31:0] b);
    br_valid_i = v; br_kind_i = k; br_cond_i = c; diff_sel_i = ds;
    pc_i = pc; offset_i = off; opa_i = a; opb_i = b;
  endtask

  task automatic drive_junk(logic force_valid);
    drive(force_valid | $urandom_range(0, 1) == 1, 2'($urandom), 3'($urandom),
          1'($urandom), $urandom & 32'hFFFF_FFFC, 16'($urandom), $urandom, $urandom);
  endtask

  // call at a negedge with the slot tracker idle
  task automatic run_branch(logic [1:0] k, logic [2:0] c, logic ds, logic [31:0] pc,
                            logic [15:0] off, logic [31:0] a, logic [31:0] b);
    logic tk;
    logic [31:0] tg;
    tk = ref_taken(k, c, ds, a, b);
    tg = ref_target(k, pc, off, a);
    drive(1'b1, k, c, ds, pc, off, a, b);
    @(negedge clk_i);
    check(tag_for(k, c), "redirect", 32'(redirect_o), 32'(tk));
    check(tk ? "R5" : "R6", "target", target_o, tk ? tg : 32'd0);
    check("R7", "link_we", 32'(link_we_o), 32'(k == 2'b10));
    check("R7", "link_addr", link_addr_o, (k == 2'b10) ? pc + 32'd12 : 32'd0);
    drive_junk(1'b1);
    @(negedge clk_i);
    check("R9", "slot1 redirect", 32'(redirect_o), 32'd0);
    check("R9", "slot1 link", 32'(link_we_o), 32'd0);
    drive_junk(1'b0);
    @(negedge clk_i);
    check("R9", "slot2 redirect", 32'(redirect_o), 32'd0);
    check("R6", "slot2 target", target_o, 32'd0);
    drive(1'b0, 2'b00, 3'd0, 1'b0, 32'd0, 16'd0, 32'd0, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7731));
    repeat (3) @(negedge clk_i);
    check("R1", "reset redirect", 32'(redirect_o), 32'd0);
    check("R1", "reset target", target_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "post reset link", 32'(link_we_o), 32'd0);
    check("R1", "post reset link_addr", link_addr_o, 32'd0);

    run_branch(2'b00, 3'd0, 1'b0, 32'h100, 16'h0010, 32'd55, 32'd55);       // R2 eq taken
    run_branch(2'b00, 3'd0, 1'b0, 32'h100, 16'h0010, 32'd55, 32'd56);       // R2 eq not
    run_branch(2'b00, 3'd1, 1'b0, 32'h200, 16'hFFFF, 32'd1, 32'd2);         // R2 ne, R5 neg off
    run_branch(2'b00, 3'd2, 1'b0, 32'h300, 16'h0004, 32'h8000_0000, 32'd0); // R3 ltz
    run_branch(2'b00, 3'd3, 1'b0, 32'h300, 16'h0004, 32'd0, 32'd0);         // R3 gtz zero: not
    run_branch(2'b00, 3'd4, 1'b0, 32'h300, 16'h0004, 32'd0, 32'd9);         // R3 lez zero
    run_branch(2'b00, 3'd5, 1'b0, 32'h300, 16'h0004, 32'hFFFF_FFFF, 32'd0); // R3 gez neg: not
    run_branch(2'b00, 3'd6, 1'b1, 32'h400, 16'h8000, 32'd77, 32'd77);       // R3 diff zero
    run_branch(2'b00, 3'd2, 1'b1, 32'h400, 16'h0001, 32'd3, 32'd5);         // R3 diff neg
    run_branch(2'b00, 3'd7, 1'b0, 32'h500, 16'h0002, 32'd0, 32'd0);         // R4
    run_branch(2'b01, 3'd0, 1'b0, 32'h600, 16'h0020, 32'd1, 32'd2);         // R7 jump
    run_branch(2'b10, 3'd6, 1'b0, 32'h700, 16'hFFF0, 32'd5, 32'd0);         // R7 call
    run_branch(2'b11, 3'd1, 1'b0, 32'h800, 16'h0000, 32'h1234_5677, 32'd0); // R8 return

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom;
      b = ($urandom_range(0, 2) == 0) ? a : $urandom;
      run_branch(2'($urandom), 3'($urandom), 1'($urandom), $urandom & 32'hFFFF_FFFC,
                 16'($urandom), a, b);
      if ($urandom_range(0, 1) == 1) @(negedge clk_i);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule